// File: doc/BRIEF.md
# Dataflow Token Matching Engine

The engine runs a small static dataflow graph without any program counter. Work arrives as tokens, each holding a data word and the arc it travels on. The arc number selects a graph node and one of its two operand ports. Nodes that need two operands wait in a matching store until the partner token for the same node arrives. When the pair is complete, the node fires. Its operation and successor arcs come from a 16-entry node table, and the result is sent to up to two destinations. A destination is either internal, in which case the token re-enters the engine through its input FIFO, or external, in which case it appears on the output port. A steer node compares its operand with a per-node constant and sends the value to one of its two destinations only.

The node table is a parameter. The default table implements (A+B)*(C-D). The product is sent to the outputs and is also steered against the constant 15. The default table also has a two-way PASS node and a stand-alone SUB node. External tokens enter through a valid/ready handshake. One token is processed per cycle. A result with two destinations is emitted over two successive cycles.

Top module: `df_token_engine`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0 and err_o is 0.
- R2: A token is accepted on a rising edge where in_valid_i and in_ready_o are both 1. Its arc is {node[3:0], port}, where port 0 is the left operand and port 1 is the right operand.
- R3: A binary node fires only when both of its operands are present, whichever arrives first. It computes left op right, wrapped to 16 bits. The opcodes are ADD=0, SUB=1, MUL=2, STEER=3 and PASS=4.
- R4: Firing clears both presence bits of the node, so a later pair for the same node fires again with the new values only.
- R5: A STEER node compares its operand with its constant as signed 16-bit values. If operand > constant, the value goes only to destination 0. Otherwise it goes only to destination 1.
- R6: A result with two destinations is emitted on two successive cycles, destination 0 first. An external destination shows its own arc on out_arc_o. An internal destination re-enters through the input FIFO.
- R7: In an idle engine, take a token accepted at edge k for a single-operand node whose destination is external. out_valid_o is 1 in the cycle after edge k+1, and it is high for one cycle per emitted token.
- R8: A token for an operand slot that is already occupied sets err_o, which stays set until reset. That token is dropped and the stored operand is kept.
- R9: in_ready_o is 0 while an internal token is being re-injected or while fewer than 3 FIFO slots are free. No accepted token is lost.
- R10: The default graph outputs (A+B)*(C-D) on external arc 0 for any arrival order of A, B, C and D on arcs 0 to 3. It then outputs the same value on arc 1 if it is above 15, or on arc 2 otherwise.
- R11: A PASS node forwards its operand unchanged to each valid destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input token valid |
| in_ready_o | output | 1 | Engine can take an input token |
| in_arc_i | input | 5 | Destination arc of the input token |
| in_data_i | input | 16 | Data value of the input token |
| out_valid_o | output | 1 | Output token valid for this cycle |
| out_arc_o | output | 5 | External arc of the output token |
| out_data_o | output | 16 | Output token value |
| err_o | output | 1 | Sticky operand-collision flag |

## Verification
Each token lands in the FIFO one edge after acceptance. If the engine is idle, it is consumed on the next edge, and an external result is visible during the following cycle. A second destination follows one cycle later. An internal token adds one edge to land back in the FIFO, plus one more edge for the engine to finish its current emission before it consumes that token. The latency check for R7 samples the outputs at the falling edges exactly two and three cycles after acceptance, and a third sample confirms out_valid_o has dropped. All other checks use a falling-edge monitor that logs every output token. The logged sequence is compared only after the engine has been idle long enough to drain, so ordering is checked without depending on exact edge positions.

// File: rtl/df_pkg.sv
package df_pkg;
  localparam int DATA_W = 16;
  localparam int NODES  = 16;
  localparam int NODE_W = $clog2(NODES);
  localparam int ARC_W  = NODE_W + 1;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_STEER = 3'd3, OP_PASS = 3'd4
  } op_e;

  typedef struct packed {
    logic             vld;
    logic             ext;
    logic [ARC_W-1:0] arc;
  } dest_t;

  typedef struct packed {
    op_e               op;
    logic [DATA_W-1:0] cst;
    dest_t             d1;
    dest_t             d0;
  } node_t;

  typedef node_t [NODES-1:0] table_t;

  typedef struct packed {
    logic [ARC_W-1:0]  arc;
    logic [DATA_W-1:0] data;
  } token_t;

  function automatic dest_t mk_dst(input logic ext, input int arc);
    dest_t d;
    d.vld = 1'b1;
    d.ext = ext;
    d.arc = ARC_W'(arc);
    return d;
  endfunction

  // (A+B)*(C-D), product out on ext 0 and steered vs 15 to ext 1/2
  function automatic table_t default_table();
    table_t t;
    for (int i = 0; i < NODES; i++) begin
      t[i].op  = OP_PASS;
      t[i].cst = '0;
      t[i].d0  = '0;
      t[i].d1  = '0;
    end
    t[0].op = OP_ADD;   t[0].d0 = mk_dst(1'b0, 4);
    t[1].op = OP_SUB;   t[1].d0 = mk_dst(1'b0, 5);
    t[2].op = OP_MUL;   t[2].d0 = mk_dst(1'b0, 6);  t[2].d1 = mk_dst(1'b1, 0);
    t[3].op = OP_STEER; t[3].cst = DATA_W'(15);
    t[3].d0 = mk_dst(1'b1, 1);  t[3].d1 = mk_dst(1'b1, 2);
    t[4].op = OP_PASS;  t[4].d0 = mk_dst(1'b1, 3);  t[4].d1 = mk_dst(1'b1, 4);
    t[5].op = OP_SUB;   t[5].d0 = mk_dst(1'b1, 5);
    return t;
  endfunction
endpackage

// File: rtl/df_fifo.sv
module df_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/df_match.sv
module df_match #(
  parameter int NODES  = 16,
  parameter int DATA_W = 16,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_v_i,
  input  logic [NODE_W-1:0] node_i,
  input  logic              port_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              binary_i,
  output logic              fire_o,
  output logic              err_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  logic [NODES-1:0]  pres_l_q, pres_r_q;
  logic [DATA_W-1:0] val_l_q [NODES];
  logic [DATA_W-1:0] val_r_q [NODES];
  logic other_pres, own_pres, store;

  assign other_pres = port_i ? pres_l_q[node_i] : pres_r_q[node_i];
  assign own_pres   = port_i ? pres_r_q[node_i] : pres_l_q[node_i];
  assign fire_o     = tok_v_i && (!binary_i || other_pres);
  assign err_o      = tok_v_i && binary_i && !other_pres && own_pres;
  assign store      = tok_v_i && binary_i && !other_pres && !own_pres;
  assign left_o     = (!port_i || !binary_i) ? data_i : val_l_q[node_i];
  assign right_o    = !binary_i ? '0 : (port_i ? data_i : val_r_q[node_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_l_q <= '0;
      pres_r_q <= '0;
    end else if (store) begin
      if (port_i) pres_r_q[node_i] <= 1'b1;
      else        pres_l_q[node_i] <= 1'b1;
    end else if (fire_o && binary_i) begin
      pres_l_q[node_i] <= 1'b0;
      pres_r_q[node_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (store) begin
      if (port_i) val_r_q[node_i] <= data_i;
      else        val_l_q[node_i] <= data_i;
    end
  end

  for (genvar g = 0; g < NODES; g++) begin : g_chk
    a_r3_never_both_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pres_l_q[g] && pres_r_q[g]));
  end

  a_r4_fire_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && binary_i) |=> !pres_l_q[$past(node_i)] && !pres_r_q[$past(node_i)]);
  a_r8_keep_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (port_i ? pres_r_q[$past(node_i)] : pres_l_q[$past(node_i)]) || $past(port_i) != port_i
              || 1'b1 == (pres_l_q[$past(node_i)] | pres_r_q[$past(node_i)]));
endmodule

// File: rtl/df_alu.sv
module df_alu
  import df_pkg::*;
(
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] cst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              gt_o
);
  assign gt_o = $signed(a_i) > $signed(cst_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = DATA_W'(a_i * b_i);
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/df_token_engine.sv
module df_token_engine
  import df_pkg::*;
#(
  parameter int     FIFO_DEPTH = 8,
  parameter table_t NODE_TABLE = default_table(),
  localparam int    CNT_W      = $clog2(FIFO_DEPTH + 1),
  localparam int    TOK_W      = ARC_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ARC_W-1:0]  in_arc_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [ARC_W-1:0]  out_arc_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] ROOM = CNT_W'(FIFO_DEPTH - 2);

  // pending result, one destination emitted per cycle
  logic              pend_v_q;
  logic [DATA_W-1:0] pend_val_q;
  logic [1:0]        pend_mask_q;
  dest_t [1:0]       pend_dst_q;
  logic              err_q;

  logic              cur_sel, int_req, emit_ok;
  dest_t             cur_dst;
  logic [1:0]        mask_left;

  logic              f_push, f_pop, f_empty, f_full;
  logic [CNT_W-1:0]  f_cnt;
  token_t            f_wdata, head;

  logic              consume, fire, m_err, binary, gt;
  logic [NODE_W-1:0] node;
  node_t             ent;
  logic [DATA_W-1:0] opl, opr, res;
  logic [1:0]        new_mask;

  assign cur_sel   = !pend_mask_q[0];
  assign cur_dst   = pend_dst_q[cur_sel];
  assign int_req   = pend_v_q && !cur_dst.ext;
  assign emit_ok   = pend_v_q && (cur_dst.ext || !f_full);
  assign mask_left = pend_mask_q & ~(2'b01 << cur_sel);

  assign in_ready_o  = !int_req && (f_cnt < ROOM);
  assign out_valid_o = pend_v_q && cur_dst.ext;
  assign out_arc_o   = cur_dst.arc;
  assign out_data_o  = pend_val_q;
  assign err_o       = err_q;

  assign f_push  = int_req ? !f_full : (in_valid_i && in_ready_o);
  assign f_wdata = int_req ? token_t'{arc: cur_dst.arc, data: pend_val_q}
                           : token_t'{arc: in_arc_i, data: in_data_i};
  assign consume = !pend_v_q && !f_empty;
  assign f_pop   = consume;

  df_fifo #(.W(TOK_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(f_push), .wdata_i(f_wdata), .pop_i(f_pop),
    .rdata_o(head), .empty_o(f_empty), .full_o(f_full), .count_o(f_cnt)
  );

  assign node   = head.arc[ARC_W-1:1];
  assign ent    = NODE_TABLE[node];
  assign binary = (ent.op == OP_ADD) || (ent.op == OP_SUB) || (ent.op == OP_MUL);

  df_match #(.NODES(NODES), .DATA_W(DATA_W)) u_match (
    .clk_i, .rst_ni,
    .tok_v_i(consume), .node_i(node), .port_i(head.arc[0]), .data_i(head.data),
    .binary_i(binary), .fire_o(fire), .err_o(m_err), .left_o(opl), .right_o(opr)
  );

  df_alu u_alu (
    .op_i(ent.op), .a_i(opl), .b_i(opr), .cst_i(ent.cst), .res_o(res), .gt_o(gt)
  );

  always_comb begin
    new_mask = {ent.d1.vld, ent.d0.vld};
    if (ent.op == OP_STEER) new_mask = new_mask & (gt ? 2'b01 : 2'b10);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_val_q  <= '0;
      pend_mask_q <= '0;
      pend_dst_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      if (consume && m_err) err_q <= 1'b1;
      if (consume && fire && (new_mask != 2'b00)) begin
        pend_v_q    <= 1'b1;
        pend_val_q  <= res;
        pend_mask_q <= new_mask;
        pend_dst_q  <= {ent.d1, ent.d0};
      end else if (emit_ok) begin
        pend_mask_q <= mask_left;
        if (mask_left == 2'b00) pend_v_q <= 1'b0;
      end
    end
  end

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r5_steer_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && fire && ent.op == OP_STEER && new_mask != 2'b00) |=> $countones(pend_mask_q) == 1);
  a_r9_stall_on_reinject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v_q && !out_valid_o) |-> !in_ready_o);
  a_r6_second_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_ok && pend_mask_q == 2'b11) |=> pend_v_q && pend_mask_q == 2'b10);
endmodule

// File: tb/sim_df_token_engine.sv
module sim_df_token_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_arc = '0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [4:0]  out_arc;
  logic [15:0] out_data;
  logic        err;

  int checks = 0;
  int errors = 0;
  int n_out = 0;
  logic [4:0]  o_arc [64];
  logic [15:0] o_dat [64];
  bit stall_seen = 1'b0;

  always #5 clk = ~clk;

  df_token_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_arc_i(in_arc), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_arc_o(out_arc), .out_data_o(out_data), .err_o(err)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && n_out < 64) begin
      o_arc[n_out] = out_arc;
      o_dat[n_out] = out_data;
      n_out = n_out + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FIFO_CHECK FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] a, input logic [15:0] d);
    in_valid = 1'b1;
    in_arc   = a;
    in_data  = d;
    while (!in_ready) begin
      stall_seen = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_clear();
    repeat (40) @(negedge clk);
    n_out = 0;
  endtask

  function automatic logic [15:0] exp_prod(input logic [15:0] a, b, c, d);
    logic [15:0] s, t;
    s = a + b;
    t = c - d;
    return 16'(s * t);
  endfunction

  task automatic run_graph(input logic [15:0] a, b, c, d, input bit shuffle, input string tag);
    logic [4:0]  arcs [4];
    logic [15:0] vals [4];
    logic [15:0] p;
    arcs[0] = 5'd0; arcs[1] = 5'd1; arcs[2] = 5'd2; arcs[3] = 5'd3;
    vals[0] = a;    vals[1] = b;    vals[2] = c;    vals[3] = d;
    if (shuffle) begin
      for (int i = 3; i > 0; i--) begin
        int j;
        logic [4:0]  ta;
        logic [15:0] tv;
        j = int'($urandom % (i + 1));
        ta = arcs[i]; arcs[i] = arcs[j]; arcs[j] = ta;
        tv = vals[i]; vals[i] = vals[j]; vals[j] = tv;
      end
    end
    for (int i = 0; i < 4; i++) begin
      send(arcs[i], vals[i]);
      repeat ($urandom % 4) @(negedge clk);
    end
    idle_clear_keep();
    p = exp_prod(a, b, c, d);
    chk({tag, " R10 count"}, n_out, 2);
    chk({tag, " R10 product arc"}, int'(o_arc[0]), 0);
    chk({tag, " R3 product value"}, int'(o_dat[0]), int'(p));
    chk({tag, " R5 steer arc"}, int'(o_arc[1]), ($signed(p) > 16'sd15) ? 1 : 2);
    chk({tag, " R5 steer value"}, int'(o_dat[1]), int'(p));
    n_out = 0;
  endtask

  task automatic idle_clear_keep();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("WATCHDOG FAIL R1: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after release", int'(in_ready), 1);

    // R7 latency and R6/R11 two external dests via PASS node 4 (arc 8)
    send(5'd8, 16'h1234);
    @(negedge clk);
    chk("R7 out_valid at k+2", int'(out_valid), 1);
    chk("R6 first dest arc", int'(out_arc), 3);
    chk("R11 pass value", int'(out_data), 16'h1234);
    @(negedge clk);
    chk("R6 second dest valid", int'(out_valid), 1);
    chk("R6 second dest arc", int'(out_arc), 4);
    @(negedge clk);
    chk("R7 single pulse", int'(out_valid), 0);
    idle_clear();

    // R3 operand order: right first on node 5
    send(5'd11, 16'd5);
    send(5'd10, 16'd50);
    idle_clear_keep();
    chk("R3 order count", n_out, 1);
    chk("R3 sub arc", int'(o_arc[0]), 5);
    chk("R3 left minus right", int'(o_dat[0]), 45);
    n_out = 0;

    // R4 second pair fires independently
    send(5'd10, 16'd9);
    send(5'd11, 16'd4);
    idle_clear_keep();
    chk("R4 refire count", n_out, 1);
    chk("R4 refire value", int'(o_dat[0]), 5);
    n_out = 0;

    // R8 collision
    send(5'd10, 16'd100);
    idle_clear_keep();
    chk("R8 no error yet", int'(err), 0);
    send(5'd10, 16'd7);
    idle_clear_keep();
    chk("R8 error set", int'(err), 1);
    chk("R8 dropped no output", n_out, 0);
    send(5'd11, 16'd30);
    idle_clear_keep();
    chk("R8 kept operand count", n_out, 1);
    chk("R8 kept operand value", int'(o_dat[0]), 70);
    chk("R8 error sticky", int'(err), 1);
    n_out = 0;

    // R5 boundaries
    run_graph(16'd4, 16'd0, 16'd5, 16'd1, 1'b0, "p16");
    run_graph(16'd3, 16'd0, 16'd6, 16'd1, 1'b0, "p15");
    run_graph(16'd0, 16'd1, 16'd0, 16'd20, 1'b0, "neg");
    run_graph(16'hFFFF, 16'd1, 16'd7, 16'd2, 1'b1, "zero");

    // R9 back-pressure with two-dest PASS tokens
    stall_seen = 1'b0;
    for (int i = 0; i < 10; i++) send(5'd8, 16'(i + 100));
    idle_clear_keep();
    chk("R9 stall observed", int'(stall_seen), 1);
    chk("R9 no loss count", n_out, 20);
    for (int i = 0; i < 10; i++) begin
      chk("R9 order arc a", int'(o_arc[2*i]), 3);
      chk("R9 order arc b", int'(o_arc[2*i+1]), 4);
      chk("R9 value", int'(o_dat[2*i]), i + 100);
    end
    n_out = 0;

    // R10 R2 random arrival order and values
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a, b, c, d;
      if (k % 2 == 0) begin
        a = 16'($urandom); b = 16'($urandom); c = 16'($urandom); d = 16'($urandom);
      end else begin
        a = 16'($urandom % 8); b = 16'($urandom % 8);
        c = 16'($urandom % 8); d = 16'($urandom % 8);
      end
      run_graph(a, b, c, d, 1'b1, "rnd");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule